// File: doc/BRIEF.md
# LCD Row Scan Sequencer

This block steps through the common (row) electrodes of a multiplexed LCD. It keeps a scan position, turns it into the display RAM row that the column path must present, and raises exactly one of 25 physical row-select outputs for that row. The number of rows is chosen by a two-bit ratio code (8, 16, 20 or 24 rows), and an icon option appends one further row. A reverse option runs the scan from the last row down to the first.

Each row step comes either from an internal prescaler of the system clock or, when the external timing source is selected, from rising edges of an asynchronous external frame input. A frame-phase bit flips each time the scan wraps, so downstream drivers can alternate polarity every frame. A sleep input blanks every row select, parks the scan at its first row and freezes the frame phase. Only logical select signals are produced; bias voltage selection belongs elsewhere.

Top module: `lcd_row_scan`

## Requirements
- R1: After reset, with ratio code 0 and reverse off, `ram_addr` is 0, `row_sel` is 0x0000001 (only output 1, bit 0) and `frame_phase` is 0.
- R2: The ratio code `mux_sel` values 0, 1, 2, 3 give 8, 16, 20 and 24 rows; `icon_en`=1 adds one row. With reverse off, `ram_addr` counts 0,1,...,n-1 and then returns to 0.
- R3: Row-select outputs are numbered 1..25 (output k is `row_sel` bit k-1). For 8, 16 and 20 rows, the first half of the rows drive outputs 1 upward and the second half drive outputs 13 upward (8 rows: 1-4 and 13-16; 16 rows: 1-8 and 13-20; 20 rows: 1-10 and 13-22). For 24 rows, rows 0..23 drive outputs 1..24 in order.
- R4: The icon row (RAM row equal to the base count) drives output 17, 21, 23 or 25 for 8, 16, 20 or 24 base rows.
- R5: With `rev_scan`=1, the scan starts at RAM row n-1, counts down to 0 and then returns to n-1.
- R6: With `ext_sel`=0 the scan advances once every `presc_limit`+1 clock cycles; after sleep is released, the first advance comes at the (`presc_limit`+1)-th rising edge.
- R7: With `ext_sel`=1 the prescaler has no effect; each rising edge of `ext_frame` advances the scan by exactly one row, visible after the third rising clock edge that follows it, however long the input stays high.
- R8: `frame_phase` flips exactly when the scan wraps from its last row to its first row, and at no other time.
- R9: While `sleep`=1, `row_sel` is all zero, `ext_frame` edges are ignored and `frame_phase` holds; after release the scan restarts at its first row.
- R10: `row_sel` never has more than one bit set, and exactly one while not asleep and the mode inputs are steady.
- R11: If the ratio or icon setting changes so that the current position is beyond the new row count, the scan restarts at its first row on the next clock edge without flipping `frame_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_sel | input | 2 | Ratio code: 0/1/2/3 = 8/16/20/24 rows |
| icon_en | input | 1 | Append one icon row |
| rev_scan | input | 1 | Scan from last row down to first |
| sleep | input | 1 | Blank outputs and park the scan |
| ext_sel | input | 1 | 1 = step on external frame edges, 0 = internal prescaler |
| ext_frame | input | 1 | Asynchronous external frame timing input |
| presc_limit | input | PRESC_W | Prescaler terminal value; period is this plus one |
| row_sel | output | 25 | One-hot physical row select |
| ram_addr | output | 5 | Display RAM row currently driven |
| frame_phase | output | 1 | AC polarity phase, flips on each wrap |

## Verification
Every combination of ratio code, icon option and scan direction is stepped through a full frame plus the wrap, comparing the RAM row and the whole select vector at each step; this separates mapping errors in the gap region, the icon output, the wrap point and the direction. The prescaler is tried with a known limit and sampled on both sides of each expected advance, while the external path is tried with a long-held high level and an exact latency probe, which separates edge detection from level sensing and off-by-one synchronizer depth. Sleep in mid-frame and a ratio change that strands the position beyond the new count show whether the restart and phase-hold rules are kept.

// File: rtl/lcd_scan_pkg.sv
// Package: shared constants and row geometry helpers for the row scan sequencer.
// Assumes at most 25 physical row outputs, with the split point of the
// smaller ratios fixed at output 13 (index 12).
package lcd_scan_pkg;

    localparam int ROW_W   = 5;
    localparam int NUM_OUT = 25;
    localparam int GAP_IDX = 12;

    // Base row count for a ratio code.
    function automatic logic [ROW_W-1:0] base_rows(input logic [1:0] code);
        logic [ROW_W-1:0] r;
        case (code)
            2'd0:    r = ROW_W'(8);
            2'd1:    r = ROW_W'(16);
            2'd2:    r = ROW_W'(20);
            default: r = ROW_W'(24);
        endcase
        return r;
    endfunction

    // Total rows including the optional icon row.
    function automatic logic [ROW_W-1:0] total_rows(input logic [1:0] code,
                                                    input logic       icon);
        return base_rows(code) + {{(ROW_W-1){1'b0}}, icon};
    endfunction

    // Physical output index (0-based) for a logical RAM row.
    function automatic logic [ROW_W-1:0] out_index(input logic [1:0]       code,
                                                   input logic [ROW_W-1:0] logical);
        logic [ROW_W-1:0] base;
        logic [ROW_W-1:0] half;
        logic [ROW_W-1:0] idx;
        base = base_rows(code);
        half = base >> 1;
        if (logical < half)
            idx = logical;
        else if (logical < base)
            idx = ROW_W'(GAP_IDX) + (logical - half);
        else
            idx = ROW_W'(GAP_IDX) + half;
        return idx;
    endfunction

endpackage

// File: rtl/lcd_tick_gen.sv
// Module: lcd_tick_gen
// Produces the single-cycle row advance strobe. Internal timing is a
// prescaler of the system clock; external timing is a rising-edge detector
// behind a two-stage synchronizer. Assumes the external input is slow
// compared with clk (high and low each for at least two cycles).
module lcd_tick_gen #(
    parameter int PRESC_W = 16,
    parameter int SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ext_sel,
    input  logic               ext_frame,
    input  logic [PRESC_W-1:0] presc_limit,
    output logic               adv
);

    localparam int CHAIN_N = SYNC_N + 1;

    logic [PRESC_W-1:0] cnt;
    logic [CHAIN_N-1:0] chain;
    logic               int_tick;
    logic               ext_tick;

    // Prescaler: counts 0..presc_limit while running on internal timing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || ext_sel || cnt == presc_limit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[CHAIN_N-2:0], ext_frame};
    end

    // Strobe selection between the two timing sources.
    always_comb begin
        int_tick = run && !ext_sel && (cnt == presc_limit);
        ext_tick = run && ext_sel && chain[SYNC_N-1] && !chain[SYNC_N];
        adv      = ext_sel ? ext_tick : int_tick;
    end

endmodule

// File: rtl/lcd_scan_counter.sv
// Module: lcd_scan_counter
// Holds the scan position (0 = first row of the frame) and the frame phase.
// Assumes row_count is at least 2 and changes only from configuration.
module lcd_scan_counter #(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adv,
    input  logic [ROW_W-1:0] row_count,
    output logic [ROW_W-1:0] pos,
    output logic             phase
);

    logic at_last;

    // Last-position detect for the wrap.
    always_comb at_last = (pos == row_count - 1'b1);

    // Position and phase update: park, restart, advance or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            phase <= 1'b0;
        end else if (!run || pos >= row_count) begin
            pos   <= '0;
        end else if (adv) begin
            if (at_last) begin
                pos   <= '0;
                phase <= ~phase;
            end else begin
                pos   <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_row_map.sv
// Module: lcd_row_map
// Decodes a logical RAM row into a one-hot physical row select using the
// fixed assignment for the chosen ratio. Purely combinational; assumes
// the caller flags out-of-range rows through row_ok.
module lcd_row_map
    import lcd_scan_pkg::*;
(
    input  logic [1:0]         mux_sel,
    input  logic [ROW_W-1:0]   logical,
    input  logic               row_ok,
    input  logic               enable,
    output logic [NUM_OUT-1:0] row_sel
);

    logic [ROW_W-1:0] phys;

    // Physical index lookup.
    always_comb phys = out_index(mux_sel, logical);

    // One comparator per output.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
        assign row_sel[k] = enable && row_ok && (phys == ROW_W'(k));
    end

endmodule

// File: rtl/lcd_row_scan.sv
// Module: lcd_row_scan (top)
// Row scan sequencer for a multiplexed LCD: selects the timing source,
// steps the scan, applies the scan direction, and drives the RAM row
// address, the one-hot row select and the frame phase.
// Assumes all mode inputs are quasi-static configuration.
module lcd_row_scan
    import lcd_scan_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mux_sel,
    input  logic               icon_en,
    input  logic               rev_scan,
    input  logic               sleep,
    input  logic               ext_sel,
    input  logic               ext_frame,
    input  logic [PRESC_W-1:0] presc_limit,
    output logic [NUM_OUT-1:0] row_sel,
    output logic [ROW_W-1:0]   ram_addr,
    output logic               frame_phase
);

    logic             run;
    logic             adv;
    logic [ROW_W-1:0] row_count;
    logic [ROW_W-1:0] pos;
    logic             pos_ok;
    logic [ROW_W-1:0] logical;

    // Run enable and active row count.
    always_comb begin
        run       = !sleep;
        row_count = total_rows(mux_sel, icon_en);
    end

    lcd_tick_gen #(
        .PRESC_W (PRESC_W),
        .SYNC_N  (2)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .ext_sel     (ext_sel),
        .ext_frame   (ext_frame),
        .presc_limit (presc_limit),
        .adv         (adv)
    );

    lcd_scan_counter #(
        .ROW_W (ROW_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .adv       (adv),
        .row_count (row_count),
        .pos       (pos),
        .phase     (frame_phase)
    );

    // Direction: forward uses the position, reverse mirrors it.
    always_comb begin
        pos_ok  = (pos < row_count);
        logical = '0;
        if (pos_ok)
            logical = rev_scan ? (row_count - 1'b1 - pos) : pos;
        ram_addr = logical;
    end

    lcd_row_map u_map (
        .mux_sel (mux_sel),
        .logical (logical),
        .row_ok  (pos_ok),
        .enable  (run),
        .row_sel (row_sel)
    );

endmodule

// File: rtl/lcd_row_scan_chk.sv
// Module: lcd_row_scan_chk
// Temporal checks on the sequencer's ports, bound into every lcd_row_scan.
module lcd_row_scan_chk
    import lcd_scan_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mux_sel,
    input logic               icon_en,
    input logic               sleep,
    input logic [NUM_OUT-1:0] row_sel,
    input logic [ROW_W-1:0]   ram_addr,
    input logic               frame_phase
);

    // R10
    row_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    // R10
    row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && $stable(mux_sel) && $stable(icon_en)) |-> ($countones(row_sel) == 1));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mux_sel) && $stable(icon_en)) |-> (ram_addr < total_rows(mux_sel, icon_en)));

    // R8
    phase_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_phase) |-> !$stable(ram_addr));

    // R9
    sleep_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep) && sleep) |-> $stable(frame_phase));

endmodule

bind lcd_row_scan lcd_row_scan_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mux_sel     (mux_sel),
    .icon_en     (icon_en),
    .sleep       (sleep),
    .row_sel     (row_sel),
    .ram_addr    (ram_addr),
    .frame_phase (frame_phase)
);

// File: tb/lcd_row_scan_tb_top.sv
module lcd_row_scan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mux_sel = 2'd0;
    logic        icon_en = 1'b0;
    logic        rev_scan = 1'b0;
    logic        sleep = 1'b0;
    logic        ext_sel = 1'b1;
    logic        ext_frame = 1'b0;
    logic [15:0] presc_limit = 16'd3;
    logic [24:0] row_sel;
    logic [4:0]  ram_addr;
    logic        frame_phase;

    int checks = 0;
    int failures = 0;
    bit exp_phase = 1'b0;

    always #4 clk = ~clk;

    lcd_row_scan #(.PRESC_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .icon_en(icon_en),
        .rev_scan(rev_scan), .sleep(sleep), .ext_sel(ext_sel),
        .ext_frame(ext_frame), .presc_limit(presc_limit),
        .row_sel(row_sel), .ram_addr(ram_addr), .frame_phase(frame_phase)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int base_of(input int code);
        return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 20 : 24;
    endfunction

    // Expected output index from R3/R4.
    function automatic int phys_of(input int code, input int row);
        int b = base_of(code);
        int h = b / 2;
        if (row < h) return row;
        if (row < b) return 12 + row - h;
        return 12 + h;
    endfunction

    task automatic step();
        @(negedge clk) ext_frame = 1'b1;
        repeat (4) @(negedge clk);
        ext_frame = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk) sleep = 1'b1;
        repeat (2) @(negedge clk);
        sleep = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ram_addr", ram_addr, 0);
        check("R1 row_sel", row_sel, 1);
        check("R1 frame_phase", frame_phase, 0);
    endtask

    // Full frame plus wrap for one configuration (R2 R3 R4 R5 R8).
    task automatic t_scan(input int code, input bit icon, input bit rev);
        int n;
        mux_sel = code[1:0]; icon_en = icon; rev_scan = rev;
        n = base_of(code) + int'(icon);
        restart();
        for (int p = 0; p <= n; p++) begin
            int row = rev ? (n - 1 - (p % n)) : (p % n);
            if (p == n) exp_phase = ~exp_phase;
            check(rev ? "R5 ram_addr" : "R2 ram_addr", ram_addr, row);
            check((icon && row == n - 1) ? "R4 row_sel" : "R3 row_sel",
                  row_sel, 1 << phys_of(code, row));
            if (p == 0 || p == n) check("R8 frame_phase", frame_phase, exp_phase);
            if (p < n) step();
        end
    endtask

    task automatic t_prescaler();
        mux_sel = 2'd0; icon_en = 1'b0; rev_scan = 1'b0;
        @(negedge clk) sleep = 1'b1; ext_sel = 1'b0; presc_limit = 16'd4;
        repeat (2) @(negedge clk);
        sleep = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 before first advance", ram_addr, 0);
        @(negedge clk);
        check("R6 first advance", ram_addr, 1);
        repeat (4) @(negedge clk);
        check("R6 before second advance", ram_addr, 1);
        @(negedge clk);
        check("R6 second advance", ram_addr, 2);
        @(negedge clk) ext_sel = 1'b1;
    endtask

    task automatic t_external();
        mux_sel = 2'd0; icon_en = 1'b0; rev_scan = 1'b0; presc_limit = 16'd2;
        restart();
        repeat (20) @(negedge clk);
        check("R7 prescaler ignored", ram_addr, 0);
        ext_frame = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 latency two edges", ram_addr, 0);
        @(negedge clk);
        check("R7 latency three edges", ram_addr, 1);
        repeat (12) @(negedge clk);
        check("R7 level held", ram_addr, 1);
        ext_frame = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sleep();
        bit ph;
        mux_sel = 2'd1; icon_en = 1'b0; rev_scan = 1'b0;
        restart();
        repeat (3) step();
        check("R9 before sleep", ram_addr, 3);
        ph = frame_phase;
        @(negedge clk) sleep = 1'b1;
        @(negedge clk);
        check("R9 blank", row_sel, 0);
        step();
        step();
        check("R9 blank after edges", row_sel, 0);
        check("R9 phase held", frame_phase, int'(ph));
        @(negedge clk) sleep = 1'b0;
        @(negedge clk);
        check("R9 restart addr", ram_addr, 0);
        check("R9 restart sel", row_sel, 1);
    endtask

    task automatic t_shrink();
        bit ph;
        mux_sel = 2'd3; icon_en = 1'b0; rev_scan = 1'b0;
        restart();
        for (int i = 0; i < 20; i++) step();
        check("R11 at row 20", ram_addr, 20);
        ph = frame_phase;
        @(negedge clk) mux_sel = 2'd0;
        @(negedge clk);
        check("R11 restart addr", ram_addr, 0);
        check("R11 restart sel", row_sel, 1);
        check("R11 phase held", frame_phase, int'(ph));
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        for (int c = 0; c < 4; c++)
            for (int ic = 0; ic < 2; ic++)
                for (int rv = 0; rv < 2; rv++)
                    t_scan(c, ic[0], rv[0]);
        t_prescaler();
        t_external();
        t_sleep();
        t_shrink();
        finish_run();
    end

endmodule